// File: doc/BRIEF.md
# VPW Transmit Symbol Synchronizer

This block decides when each symbol that a single-wire variable-pulse-width bus node transmits should end. The symbol length is measured from what the node's own receiver sees, not from when the node started driving. The encoder asks for a symbol with a type and a bus level. The block drives the output pin to that level and then watches the filtered receive input. When the receive input first shows the requested level, the block loads the symbol's nominal length, less the transceiver delay and the fixed filter delay. It counts that down and then pulses `end_symbol` so the encoder can move on to the next symbol.

Timing always follows the received edge. If another node drives the bus to the same level a little earlier, this node follows that node's timing. Every symbol is handled this way, so bitwise arbitration stays valid inside data bytes. The count ends at a bit boundary. If the bus level at that point differs from the level being driven, the node has lost arbitration. The block then releases its output pin and raises a sticky flag. Only a start-of-frame request clears that flag. One clock is one microsecond of bus time.

Top module: `vpw_sym_sync`

## Requirements
- R1: After reset `tx_out`, `end_symbol` and `arb_lost` are 0, and the transceiver-delay register holds 14.
- R2: A `start_symbol` pulse seen while the block is idle is accepted, and `tx_out` takes the value of `drive_level` on the following clock edge.
- R3: Call e the first clock edge at which `rx_filt` equals the driven level. The symbol length N is the nominal length minus the delay register minus 8. `end_symbol` is high in the cycle that follows edge e+N.
- R4: Nominal lengths by `symbol_type` code: 0 = short data symbol, 64; 1 = long data symbol, 128; 2 = start of frame, 200; 3 = end-of-data delimiter, 200.
- R5: A write pulse on `dly_wr` loads `dly_wdata` into the delay register. Every symbol whose timing starts after the write uses the new value.
- R6: `end_symbol` is high for exactly one cycle per completed symbol.
- R7: A `start_symbol` pulse that arrives while a symbol is in progress is ignored. It does not change `tx_out` and does not change the symbol's end time.
- R8: Suppose `rx_filt` differs from the driven level at the edge where the count expires. Then `arb_lost` rises, `tx_out` drops to 0 and no `end_symbol` pulse is produced.
- R9: While `arb_lost` is 1, start requests with a type other than start of frame (code 2) are ignored. A start-of-frame request is accepted and clears `arb_lost`.
- R10: Resynchronization case: if `rx_filt` already equals the requested level at the edge where the start is accepted, timing begins at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock, one cycle per microsecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| dly_wr | input | 1 | Write strobe for the delay register |
| dly_wdata | input | 5 | Transceiver delay in clocks |
| start_symbol | input | 1 | Encoder request to begin a symbol |
| symbol_type | input | 2 | Symbol length code |
| drive_level | input | 1 | Bus level for the symbol, 1 = active |
| rx_filt | input | 1 | Filtered echo of the bus |
| tx_out | output | 1 | Output pin to the transceiver |
| end_symbol | output | 1 | One-cycle strobe that ends the symbol |
| arb_lost | output | 1 | Sticky lost-arbitration flag |

## Verification
The checker tests four things on every cycle. `end_symbol` is a single-cycle pulse. A completed symbol always agrees with the level just received. `tx_out` changes only after a start request or when arbitration is lost. `arb_lost` clears only after a start-of-frame request. The exact symbol lengths can only be shown by the bench's scenarios. Those scenarios cover each type code, delay values from 0 to 31, late and early echoes, the reset value of the delay register, a start request made while a symbol is already running, and a loss followed by a restart.

// File: rtl/vpw_sym_sync.sv
module vpw_sym_sync #(
  parameter int DLY_W = 5,
  parameter int DLY_RST = 14,
  parameter int FILT_DLY = 8,
  parameter int T_SHORT = 64,
  parameter int T_LONG = 128,
  parameter int T_SOF = 200,
  parameter int T_EOD = 200,
  parameter logic [1:0] SOF_CODE = 2'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dly_wr,
  input  logic [DLY_W-1:0] dly_wdata,
  input  logic             start_symbol,
  input  logic [1:0]       symbol_type,
  input  logic             drive_level,
  input  logic             rx_filt,
  output logic             tx_out,
  output logic             end_symbol,
  output logic             arb_lost
);
  localparam int T_A = (T_SHORT > T_LONG) ? T_SHORT : T_LONG;
  localparam int T_B = (T_SOF > T_EOD) ? T_SOF : T_EOD;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int CW = $clog2(T_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_TIME} st_t;

  st_t             st_q;
  logic [DLY_W-1:0] dly_q;
  logic [1:0]      typ_q;
  logic            lvl_q, tx_q, end_q, lost_q;
  logic [CW-1:0]   cnt_q, nom, load_val;
  logic [1:0]      sel_type;
  logic            accept;

  assign sel_type = (st_q == S_IDLE) ? symbol_type : typ_q;

  always_comb begin
    unique case (sel_type)
      2'd0:    nom = CW'(T_SHORT);
      2'd1:    nom = CW'(T_LONG);
      2'd2:    nom = CW'(T_SOF);
      default: nom = CW'(T_EOD);
    endcase
  end

  assign load_val = nom - CW'(dly_q) - CW'(FILT_DLY) - CW'(1);
  assign accept = (st_q == S_IDLE) && start_symbol &&
                  (!lost_q || symbol_type == SOF_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      dly_q  <= DLY_W'(DLY_RST);
      typ_q  <= 2'd0;
      lvl_q  <= 1'b0;
      tx_q   <= 1'b0;
      end_q  <= 1'b0;
      lost_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      end_q <= 1'b0;
      if (dly_wr) dly_q <= dly_wdata;
      unique case (st_q)
        S_IDLE: if (accept) begin
          lost_q <= 1'b0;
          tx_q   <= drive_level;
          lvl_q  <= drive_level;
          typ_q  <= symbol_type;
          if (rx_filt == drive_level) begin
            cnt_q <= load_val;
            st_q  <= S_TIME;
          end else begin
            st_q <= S_WAIT;
          end
        end
        S_WAIT: if (rx_filt == lvl_q) begin
          cnt_q <= load_val;
          st_q  <= S_TIME;
        end
        S_TIME: if (cnt_q == '0) begin
          st_q <= S_IDLE;
          if (rx_filt == lvl_q) begin
            end_q <= 1'b1;
          end else begin
            lost_q <= 1'b1;
            tx_q   <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign tx_out = tx_q;
  assign end_symbol = end_q;
  assign arb_lost = lost_q;
endmodule

// File: rtl/vpw_sym_sync_chk.sv
module vpw_sym_sync_chk #(
  parameter logic [1:0] SOF_CODE = 2'd2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_symbol,
  input logic [1:0] symbol_type,
  input logic       rx_filt,
  input logic       tx_out,
  input logic       end_symbol,
  input logic       arb_lost
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!tx_out && !end_symbol && !arb_lost));

  assert_end_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    end_symbol |=> !end_symbol);

  assert_end_matches_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_symbol |-> ($past(rx_filt) == tx_out));

  assert_loss_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (!tx_out && !end_symbol));

  assert_tx_change_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out != $past(tx_out)) |-> ($past(start_symbol) || arb_lost));

  assert_loss_clear_sof_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arb_lost) |-> ($past(start_symbol) && $past(symbol_type) == SOF_CODE));
endmodule

bind vpw_sym_sync vpw_sym_sync_chk #(.SOF_CODE(SOF_CODE)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_symbol(start_symbol),
  .symbol_type(symbol_type), .rx_filt(rx_filt), .tx_out(tx_out),
  .end_symbol(end_symbol), .arb_lost(arb_lost));

// File: tb/vpw_sym_sync_tb.sv
`timescale 1ns/1ps
module vpw_sym_sync_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dly_wr = 1'b0;
  logic [4:0] dly_wdata = '0;
  logic start_symbol = 1'b0, drive_level = 1'b0, rx_filt = 1'b0;
  logic [1:0] symbol_type = '0;
  logic tx_out, end_symbol, arb_lost;
  int checks = 0, errors = 0;

  vpw_sym_sync dut_i (
    .clk(clk), .rst_n(rst_n), .dly_wr(dly_wr), .dly_wdata(dly_wdata),
    .start_symbol(start_symbol), .symbol_type(symbol_type),
    .drive_level(drive_level), .rx_filt(rx_filt), .tx_out(tx_out),
    .end_symbol(end_symbol), .arb_lost(arb_lost));

  always #2.5 clk = ~clk;

  // {delay, type, level, echo cycle, expected first cycle of end_symbol}
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{14, 2, 1, 22, 201},
    '{14, 0, 0, 22, 65},
    '{14, 1, 1, 22, 129},
    '{14, 3, 0, 5, 184},
    '{0, 0, 1, 8, 65},
    '{31, 1, 0, 0, 90},
    '{20, 2, 1, 0, 173}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_dly(input int v);
    @(negedge clk);
    dly_wr = 1'b1; dly_wdata = 5'(v);
    @(negedge clk);
    dly_wr = 1'b0;
  endtask

  // returns first cycle where end_symbol or arb_lost is seen (0 if none)
  task automatic run_sym(input int typ, input int lvl, input int e, input int flip,
                         input int poke, output int got, output bit saw_end);
    @(negedge clk);
    rx_filt = (e == 0) ? 1'(lvl) : ~1'(lvl);
    @(negedge clk);
    start_symbol = 1'b1; symbol_type = 2'(typ); drive_level = 1'(lvl);
    got = 0; saw_end = 1'b0;
    for (int c = 1; c < 400; c++) begin
      @(negedge clk);
      start_symbol = 1'b0;
      if (c == 1) check(tx_out == 1'(lvl), "R2", int'(tx_out), lvl);
      if (end_symbol || arb_lost) begin
        got = c; saw_end = end_symbol;
        break;
      end
      if (c == e) rx_filt = 1'(lvl);
      if (flip != 0 && c == flip) rx_filt = ~1'(lvl);
      if (poke != 0 && c == poke) begin
        start_symbol = 1'b1; symbol_type = 2'd2; drive_level = ~1'(lvl);
      end
      if (poke != 0 && c == poke + 2)
        check(tx_out == 1'(lvl), "R7", int'(tx_out), lvl);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int got;
    bit se;
    repeat (3) @(negedge clk);
    check(!tx_out && !end_symbol && !arb_lost, "R1", int'({tx_out, end_symbol, arb_lost}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_out && !end_symbol && !arb_lost, "R1", int'({tx_out, end_symbol, arb_lost}), 0);

    // R1 delay reset value 14: SOF, early echo -> 200-14-8 = 178 -> cycle 179
    run_sym(2, 1, 0, 0, 0, got, se);
    check(se && got == 179, "R1", got, 179);

    // R3 R4 R5 R10 table walk
    for (int i = 0; i < NV; i++) begin
      write_dly(VEC[i][0]);
      run_sym(VEC[i][1], VEC[i][2], VEC[i][3], 0, 0, got, se);
      check(se && got == VEC[i][4], (VEC[i][3] == 0) ? "R10" : "R3", got, VEC[i][4]);
      @(negedge clk);
      check(!end_symbol, "R6", int'(end_symbol), 0);
    end

    // R7: start during symbol ignored
    write_dly(14);
    run_sym(0, 0, 22, 0, 10, got, se);
    check(se && got == 65, "R7", got, 65);

    // R8: bus disagrees at boundary
    run_sym(0, 1, 3, 20, 0, got, se);
    check(!se && got == 46 && arb_lost, "R8", got, 46);
    check(!tx_out, "R8", int'(tx_out), 0);

    // R9: non-SOF start ignored after loss
    @(negedge clk);
    rx_filt = 1'b0;
    start_symbol = 1'b1; symbol_type = 2'd0; drive_level = 1'b1;
    @(negedge clk);
    start_symbol = 1'b0;
    repeat (5) @(negedge clk);
    check(!tx_out && arb_lost && !end_symbol, "R9", int'({tx_out, arb_lost}), 1);

    // R9: SOF clears loss
    run_sym(2, 1, 0, 0, 0, got, se);
    check(se && got == 179, "R9", got, 179);
    check(!arb_lost, "R9", int'(arb_lost), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule